// File: doc/BRIEF.md
# Split Set-Associative Translation Cache

This block caches virtual-to-physical page translations for a processor. It has two halves, one for instruction fetches and one for data accesses. Each half has 16 sets and a parameterized number of ways. A lookup that hits returns the physical address, which is the cached page frame with the page-offset bits of the request laid over it. The hit can also raise a protection fault. A lookup that misses asks an external table walker for the page descriptor, installs the answer and then replays the lookup against the new entry, so the permission checks still apply. A write to a page whose modified flag is clear also sends the request to the walker. The walker's answer then overwrites the same way.

Software controls the block through a two-bit translation-control write that selects enable and page size (4 KiB or 8 KiB). That write also empties the whole cache. Flush requests remove a single page from both halves, or remove every entry. Entries marked global survive a flush unless the request asks for them too. Only one request is in flight at a time: the block accepts a control write, a flush or a lookup only while `lk_ready` is high, and it takes them in that order of priority.

Top module: `xlat_cache`

## Requirements
- R1: After reset every entry is invalid, translation is off, the victim counter and both last-hit way registers are zero, `lk_ready` is high and `lk_done` and `walk_req` are low; the first lookup of a page after enabling therefore misses.
- R2: With translation off, an accepted lookup completes on the next cycle with `lk_phys` equal to `lk_addr`, `lk_fault` low and no walk request.
- R3: On a miss, `walk_req` rises the cycle after acceptance and stays high with `walk_addr` holding the lookup address until `walk_ack`. The answer's `walk_perm` is encoded bit 4 global, bit 3 supervisor-only, bit 2 modified, bit 1 write-protected, bit 0 resident. The entry is installed at the acknowledge edge, and `lk_done` follows one cycle later with the frame (its offset bits cleared) ORed with the offset bits of the address, which are bits 11:0 for 4 KiB pages.
- R4: With 8 KiB pages, the set index is address bits 16:13, the offset is bits 12:0 (bit 12 of the frame is dropped), and the tag compares address bits 31:17.
- R5: A hit that needs no walk completes on the cycle after acceptance without a walk request.
- R6: The supervisor flag is part of the tag, so the same page looked up with the other privilege misses.
- R7: A hit or a replay faults when it writes a write-protected page, when a user access reaches a supervisor-only page, or when the entry is not resident.
- R8: A non-faulting write that hits an entry with the modified flag clear requests a walk, and the result overwrites that same way; the other ways of the set keep their entries.
- R9: A miss fills the lowest-numbered invalid way of its set. If every way is valid, it evicts the way given by a counter. The counter advances on every accepted lookup while translation is on, so the miss that forms the n-th such lookup since reset evicts way n mod WAYS.
- R10: `lk_data` selects the half (1 data, 0 instruction); an entry installed in one half never hits in the other.
- R11: A single-page flush invalidates the entry whose tag matches `fl_addr` and `fl_super`, in both halves. A global entry survives the flush unless `fl_glob` is set.
- R12: A flush-all invalidates every entry, except global entries when `fl_glob` is clear.
- R13: A translation-control write sets enable from `tc_wdata[15]` and 8 KiB pages from `tc_wdata[14]`, and invalidates every entry, global ones included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tc_we | input | 1 | Translation-control write strobe |
| tc_wdata | input | 2 | Bits 15 (enable) and 14 (8 KiB pages) of the control word |
| lk_valid | input | 1 | Lookup request |
| lk_ready | output | 1 | Block idle; requests are accepted |
| lk_addr | input | 32 | Virtual address |
| lk_super | input | 1 | Supervisor access |
| lk_data | input | 1 | 1 data half, 0 instruction half |
| lk_write | input | 1 | Access is a write |
| lk_done | output | 1 | Lookup result valid (one cycle) |
| lk_fault | output | 1 | Protection fault for the finished lookup |
| lk_phys | output | 32 | Physical address |
| walk_req | output | 1 | Table walk requested |
| walk_addr | output | 32 | Address to walk |
| walk_super | output | 1 | Privilege of the walked access |
| walk_write | output | 1 | Walked access is a write |
| walk_ack | input | 1 | Walker answer valid |
| walk_frame | input | 32 | Physical frame from the walker |
| walk_perm | input | 5 | Status bits {global, super, modified, wprot, resident} |
| fl_valid | input | 1 | Flush request |
| fl_all | input | 1 | Flush every entry |
| fl_glob | input | 1 | Flush global entries too |
| fl_addr | input | 32 | Page to flush |
| fl_super | input | 1 | Privilege of the page to flush |

## Verification
The main table drives lookups to a few pages, crossing privilege, half, direction and the walker's answer. It separates hits from misses through the presence of a walk. It separates clean pages from modified ones through a write that must walk again. It separates the three fault causes, both on a replay and on a later hit. A fill of one set past its capacity shows which way is evicted. A write to a clean page in a full set shows that the rewalk keeps its own way and does not evict a neighbour. Flush patterns with and without the global option, followed by lookups, show which entries survive. The last pattern switches the page size and uses two addresses that share an 8 KiB page but not a 4 KiB one, together with a frame whose bit 12 is set.

// File: rtl/xc_pkg.sv
package xc_pkg;
  localparam int SETS  = 16;
  localparam int IDX_W = $clog2(SETS);

  typedef struct packed {
    logic g;  // kept by flushes without the global option
    logic s;  // supervisor only
    logic m;  // page already written
    logic w;  // write protected
    logic r;  // resident
  } perm_t;

  typedef struct packed {
    logic [31:0] tag;
    logic [31:0] frame;
    perm_t       p;
  } ent_t;

  typedef enum logic [1:0] {ST_IDLE, ST_WALK, ST_REPLAY} st_t;

  function automatic logic [31:0] tag_of(input logic [31:0] a, input logic sup, input logic big);
    return {sup, a[31:1]} & (big ? 32'hFFFF_0000 : 32'hFFFF_8000);
  endfunction

  function automatic logic [IDX_W-1:0] idx_of(input logic [31:0] a, input logic big);
    return big ? a[16:13] : a[15:12];
  endfunction

  function automatic logic [31:0] off_mask(input logic big);
    return big ? 32'h0000_1FFF : 32'h0000_0FFF;
  endfunction
endpackage

// File: rtl/xc_half.sv
module xc_half
  import xc_pkg::*;
#(
  parameter int WAYS = 4,
  localparam int WW = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] q_idx,
  input  logic [31:0]      q_tag,
  input  logic [WW-1:0]    q_start,
  output logic             q_hit,
  output logic [WW-1:0]    q_way,
  output ent_t             q_ent,
  output logic             q_free,
  output logic [WW-1:0]    q_free_way,
  input  logic             wr_en,
  input  logic [WW-1:0]    wr_way,
  input  logic [IDX_W-1:0] wr_idx,
  input  ent_t             wr_ent,
  input  logic             fl_one,
  input  logic             fl_all,
  input  logic             fl_glob,
  input  logic [IDX_W-1:0] fl_idx,
  input  logic [31:0]      fl_tag,
  input  logic             clr
);
  logic [SETS-1:0] vld_q [WAYS];
  logic [SETS-1:0] vld_d [WAYS];
  ent_t            ent_q [WAYS][SETS];
  logic [WAYS-1:0] hv;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hv[w] = vld_q[w][q_idx] && (ent_q[w][q_idx].tag == q_tag);
  end

  // search starts at the last way that hit in this half
  always_comb begin
    logic [WW-1:0] cand;
    q_hit = 1'b0;
    q_way = q_start;
    for (int k = 0; k < WAYS; k++) begin
      cand = q_start + WW'(k);
      if (!q_hit && hv[cand]) begin
        q_hit = 1'b1;
        q_way = cand;
      end
    end
  end
  assign q_ent = ent_q[q_way][q_idx];

  always_comb begin
    q_free     = 1'b0;
    q_free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!vld_q[w][q_idx]) begin
        q_free     = 1'b1;
        q_free_way = WW'(w);
      end
    end
  end

  always_comb begin
    vld_d = vld_q;
    for (int w = 0; w < WAYS; w++) begin
      for (int s = 0; s < SETS; s++) begin
        if (clr)
          vld_d[w][s] = 1'b0;
        else if (fl_all && (fl_glob || !ent_q[w][s].p.g))
          vld_d[w][s] = 1'b0;
        else if (fl_one && (IDX_W'(s) == fl_idx) && (ent_q[w][s].tag == fl_tag)
                 && (fl_glob || !ent_q[w][s].p.g))
          vld_d[w][s] = 1'b0;
      end
    end
    if (wr_en) vld_d[wr_way][wr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '{default: '0};
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) ent_q[wr_way][wr_idx] <= wr_ent;
  end
endmodule

// File: rtl/xc_victim.sv
module xc_victim #(
  parameter int WAYS = 4,
  localparam int WW = $clog2(WAYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          keep,
  input  logic [WW-1:0] keep_way,
  input  logic          free,
  input  logic [WW-1:0] free_way,
  output logic [WW-1:0] way
);
  logic [WW-1:0] rnd_q, rnd_d;

  always_comb begin
    rnd_d = rnd_q;
    if (step) rnd_d = rnd_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rnd_q <= '0;
    else        rnd_q <= rnd_d;
  end

  assign way = keep ? keep_way : (free ? free_way : WW'(rnd_q + 1'b1));
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xc_pkg::*;
#(
  parameter int WAYS = 4,
  localparam int WW = $clog2(WAYS)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tc_we,
  input  logic [15:14] tc_wdata,
  input  logic         lk_valid,
  output logic         lk_ready,
  input  logic [31:0]  lk_addr,
  input  logic         lk_super,
  input  logic         lk_data,
  input  logic         lk_write,
  output logic         lk_done,
  output logic         lk_fault,
  output logic [31:0]  lk_phys,
  output logic         walk_req,
  output logic [31:0]  walk_addr,
  output logic         walk_super,
  output logic         walk_write,
  input  logic         walk_ack,
  input  logic [31:0]  walk_frame,
  input  logic [4:0]   walk_perm,
  input  logic         fl_valid,
  input  logic         fl_all,
  input  logic         fl_glob,
  input  logic [31:0]  fl_addr,
  input  logic         fl_super
);
  logic [1:0] rs_q;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  st_t           st_q, st_d;
  logic          en_q, en_d, big_q, big_d;
  logic          done_q, done_d, fault_q, fault_d;
  logic [31:0]   phys_q, phys_d;
  logic [WW-1:0] last_q [2];
  logic [WW-1:0] last_d [2];
  logic [31:0]   rq_addr;
  logic          rq_super, rq_data, rq_write;
  logic [WW-1:0] rq_way;

  logic          lk_step, clr, fl_one_s, fl_all_s, wr_go;
  logic [31:0]   cur_addr;
  logic          cur_sup, cur_dat, cur_wr;
  logic [31:0]   cur_tag;
  logic [IDX_W-1:0] cur_idx;
  logic          hit_h [2];
  logic [WW-1:0] way_h [2];
  ent_t          ent_h [2];
  logic          free_h [2];
  logic [WW-1:0] fway_h [2];
  logic          hit, fault_c, rewalk;
  logic [WW-1:0] hway, vway;
  ent_t          e, new_ent;
  logic [31:0]   phys_c;

  assign cur_addr = (st_q == ST_REPLAY) ? rq_addr  : lk_addr;
  assign cur_sup  = (st_q == ST_REPLAY) ? rq_super : lk_super;
  assign cur_dat  = (st_q == ST_REPLAY) ? rq_data  : lk_data;
  assign cur_wr   = (st_q == ST_REPLAY) ? rq_write : lk_write;
  assign cur_tag  = tag_of(cur_addr, cur_sup, big_q);
  assign cur_idx  = idx_of(cur_addr, big_q);

  assign wr_go         = (st_q == ST_WALK) && walk_ack;
  assign new_ent.tag   = tag_of(rq_addr, rq_super, big_q);
  assign new_ent.frame = walk_frame & ~off_mask(big_q);
  assign new_ent.p     = perm_t'(walk_perm);

  for (genvar h = 0; h < 2; h++) begin : g_half
    xc_half #(.WAYS(WAYS)) u_half (
      .clk, .rst_n(rst_s),
      .q_idx(cur_idx), .q_tag(cur_tag), .q_start(last_q[h]),
      .q_hit(hit_h[h]), .q_way(way_h[h]), .q_ent(ent_h[h]),
      .q_free(free_h[h]), .q_free_way(fway_h[h]),
      .wr_en(wr_go && (rq_data == (h == 1))), .wr_way(rq_way),
      .wr_idx(idx_of(rq_addr, big_q)), .wr_ent(new_ent),
      .fl_one(fl_one_s), .fl_all(fl_all_s), .fl_glob(fl_glob),
      .fl_idx(idx_of(fl_addr, big_q)), .fl_tag(tag_of(fl_addr, fl_super, big_q)),
      .clr(clr)
    );
  end

  assign hit     = hit_h[cur_dat];
  assign hway    = way_h[cur_dat];
  assign e       = ent_h[cur_dat];
  assign fault_c = (e.p.w && cur_wr) || (e.p.s && !cur_sup) || !e.p.r;
  assign rewalk  = hit && !fault_c && cur_wr && !e.p.m;
  assign phys_c  = e.frame | (cur_addr & off_mask(big_q));

  xc_victim #(.WAYS(WAYS)) u_victim (
    .clk, .rst_n(rst_s), .step(lk_step),
    .keep(rewalk), .keep_way(hway),
    .free(free_h[cur_dat]), .free_way(fway_h[cur_dat]),
    .way(vway)
  );

  always_comb begin
    st_d = st_q; en_d = en_q; big_d = big_q;
    done_d = 1'b0; fault_d = 1'b0; phys_d = phys_q;
    last_d = last_q;
    lk_step = 1'b0; clr = 1'b0; fl_one_s = 1'b0; fl_all_s = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (tc_we) begin
          en_d = tc_wdata[15]; big_d = tc_wdata[14]; clr = 1'b1;
        end else if (fl_valid) begin
          fl_one_s = !fl_all; fl_all_s = fl_all;
        end else if (lk_valid) begin
          if (!en_q) begin
            done_d = 1'b1; phys_d = lk_addr;
          end else begin
            lk_step = 1'b1;
            if (hit && !rewalk) begin
              done_d = 1'b1; fault_d = fault_c; phys_d = phys_c;
              if (!fault_c) last_d[cur_dat] = hway;
            end else begin
              st_d = ST_WALK;
            end
          end
        end
      end
      ST_WALK: if (walk_ack) st_d = ST_REPLAY;
      default: begin
        done_d = 1'b1; fault_d = fault_c; phys_d = phys_c;
        if (!fault_c) last_d[rq_data] = rq_way;
        st_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      st_q <= ST_IDLE; en_q <= 1'b0; big_q <= 1'b0;
      done_q <= 1'b0; fault_q <= 1'b0; last_q <= '{default: '0};
    end else begin
      st_q <= st_d; en_q <= en_d; big_q <= big_d;
      done_q <= done_d; fault_q <= fault_d; last_q <= last_d;
    end
  end

  always_ff @(posedge clk) begin
    if (lk_step) begin
      rq_addr <= lk_addr; rq_super <= lk_super; rq_data <= lk_data;
      rq_write <= lk_write; rq_way <= vway;
    end
    if (done_d) phys_q <= phys_d;
  end

  assign lk_ready   = (st_q == ST_IDLE);
  assign lk_done    = done_q;
  assign lk_fault   = fault_q;
  assign lk_phys    = phys_q;
  assign walk_req   = (st_q == ST_WALK);
  assign walk_addr  = rq_addr;
  assign walk_super = rq_super;
  assign walk_write = rq_write;
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk (
  input logic        clk,
  input logic        rst_s,
  input logic        en_q,
  input logic        tc_we,
  input logic        fl_valid,
  input logic        lk_valid,
  input logic        lk_ready,
  input logic [31:0] lk_addr,
  input logic        lk_done,
  input logic        lk_fault,
  input logic [31:0] lk_phys,
  input logic        walk_req,
  input logic        walk_ack,
  input logic [31:0] walk_addr
);
  a_r2_bypass: assert property (@(posedge clk) disable iff (!rst_s)
    (lk_valid && lk_ready && !tc_we && !fl_valid && !en_q)
      |=> (lk_done && !lk_fault && !walk_req && lk_phys == $past(lk_addr)));

  a_r3_walk_hold: assert property (@(posedge clk) disable iff (!rst_s)
    (walk_req && !walk_ack) |=> (walk_req && $stable(walk_addr)));

  a_r3_replay_done: assert property (@(posedge clk) disable iff (!rst_s)
    (walk_req && walk_ack) |=> (!walk_req && !lk_done) ##1 lk_done);

  a_r3_busy_silent: assert property (@(posedge clk) disable iff (!rst_s)
    !lk_ready |-> !lk_done);

  a_r7_fault_on_done: assert property (@(posedge clk) disable iff (!rst_s)
    lk_fault |-> lk_done);
endmodule

bind xlat_cache xlat_cache_chk u_chk (
  .clk, .rst_s, .en_q, .tc_we, .fl_valid, .lk_valid, .lk_ready, .lk_addr,
  .lk_done, .lk_fault, .lk_phys, .walk_req, .walk_ack, .walk_addr
);

// File: tb/xlat_cache_bench.sv
module xlat_cache_bench;
  localparam int NW = 4;

  typedef struct packed {
    logic [31:0] addr;
    logic        sup, dat, wr;
    logic [31:0] frame;
    logic [4:0]  perm;   // {g,s,m,w,r}
    logic        xwalk;
    logic [31:0] xphys;
    logic        xfault;
  } vec_t;

  // 4 KiB pages, translation on
  localparam vec_t VEC [12] = '{
    '{32'h0001_2345, 1'b0, 1'b1, 1'b0, 32'h0040_0000, 5'b00101, 1'b1, 32'h0040_0345, 1'b0}, // R1 R3 first miss
    '{32'h0001_2345, 1'b0, 1'b1, 1'b0, 32'h0,         5'b00000, 1'b0, 32'h0040_0345, 1'b0}, // R5 hit
    '{32'h0001_2FFC, 1'b1, 1'b1, 1'b0, 32'h0050_0000, 5'b00001, 1'b1, 32'h0050_0FFC, 1'b0}, // R6 super misses
    '{32'h0001_2010, 1'b0, 1'b0, 1'b0, 32'h0060_0000, 5'b00001, 1'b1, 32'h0060_0010, 1'b0}, // R10 other half
    '{32'h0001_2020, 1'b0, 1'b1, 1'b1, 32'h0,         5'b00000, 1'b0, 32'h0040_0020, 1'b0}, // R5 write hit, modified
    '{32'h0001_2000, 1'b1, 1'b1, 1'b1, 32'h0050_0000, 5'b00101, 1'b1, 32'h0050_0000, 1'b0}, // R8 clean write walks
    '{32'h0003_3000, 1'b0, 1'b1, 1'b1, 32'h0070_0000, 5'b00011, 1'b1, 32'h0,         1'b1}, // R7 replay wprot
    '{32'h0003_3004, 1'b0, 1'b1, 1'b0, 32'h0,         5'b00000, 1'b0, 32'h0070_0004, 1'b0}, // R7 read ok
    '{32'h0004_4000, 1'b0, 1'b1, 1'b0, 32'h0080_0000, 5'b01101, 1'b1, 32'h0,         1'b1}, // R7 user on super
    '{32'h0004_4008, 1'b1, 1'b1, 1'b0, 32'h0080_0000, 5'b01101, 1'b1, 32'h0080_0008, 1'b0}, // R6 R7 super ok
    '{32'h0005_5000, 1'b0, 1'b1, 1'b0, 32'h0,         5'b00000, 1'b1, 32'h0,         1'b1}, // R7 not resident
    '{32'h0005_5000, 1'b0, 1'b1, 1'b0, 32'h0,         5'b00000, 1'b0, 32'h0,         1'b1}  // R7 hit not resident
  };

  logic clk, rst_n;
  logic tc_we; logic [15:14] tc_wdata;
  logic lk_valid, lk_ready, lk_super, lk_data, lk_write, lk_done, lk_fault;
  logic [31:0] lk_addr, lk_phys;
  logic walk_req, walk_super, walk_write, walk_ack;
  logic [31:0] walk_addr, walk_frame; logic [4:0] walk_perm;
  logic fl_valid, fl_all, fl_glob, fl_super; logic [31:0] fl_addr;

  int checks = 0, errors = 0, nlook = 0, v = 0;
  bit en_model = 0;

  xlat_cache #(.WAYS(NW)) u_xlat_cache (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, got, exp);
    end
  endtask

  task automatic look(input logic [31:0] a, input logic s, d, w,
                      input logic [31:0] fr, input logic [4:0] pm,
                      input logic xw, input logic [31:0] xp, input logic xf, input string rq);
    int guard = 0;
    logic walked = 1'b0;
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a; lk_super = s; lk_data = d; lk_write = w;
    @(negedge clk);
    lk_valid = 1'b0;
    if (en_model) nlook++;
    while (!lk_done && guard < 50) begin
      if (walk_req) begin
        chk(walk_addr == a, rq, "walk address", walk_addr, a);
        walked = 1'b1; walk_ack = 1'b1; walk_frame = fr; walk_perm = pm;
        @(negedge clk);
        walk_ack = 1'b0;
      end else @(negedge clk);
      guard++;
    end
    chk(lk_done, rq, "done", 32'(lk_done), 32'd1);
    chk(walked == xw, rq, "walk issued", 32'(walked), 32'(xw));
    chk(lk_fault == xf, rq, "fault", 32'(lk_fault), 32'(xf));
    if (!xf) chk(lk_phys == xp, rq, "phys", lk_phys, xp);
  endtask

  task automatic flush(input logic all, glob, input logic [31:0] a, input logic s);
    @(negedge clk);
    fl_valid = 1'b1; fl_all = all; fl_glob = glob; fl_addr = a; fl_super = s;
    @(negedge clk);
    fl_valid = 1'b0;
  endtask

  task automatic tcw(input logic [1:0] val);
    @(negedge clk);
    tc_we = 1'b1; tc_wdata = val; en_model = val[1];
    @(negedge clk);
    tc_we = 1'b0;
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tc_we = 0; tc_wdata = '0; lk_valid = 0; lk_addr = '0;
    lk_super = 0; lk_data = 0; lk_write = 0; walk_ack = 0; walk_frame = '0;
    walk_perm = '0; fl_valid = 0; fl_all = 0; fl_glob = 0; fl_addr = '0; fl_super = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(lk_ready == 1'b1, "R1", "ready", 32'(lk_ready), 32'd1);
    chk(lk_done == 1'b0, "R1", "done", 32'(lk_done), 32'd0);
    chk(walk_req == 1'b0, "R1", "walk_req", 32'(walk_req), 32'd0);
    // R2 translation off
    look(32'h1234_5678, 1'b0, 1'b1, 1'b1, 32'h0, 5'b0, 1'b0, 32'h1234_5678, 1'b0, "R2");

    tcw(2'b10);
    foreach (VEC[i])
      look(VEC[i].addr, VEC[i].sup, VEC[i].dat, VEC[i].wr, VEC[i].frame, VEC[i].perm,
           VEC[i].xwalk, VEC[i].xphys, VEC[i].xfault, $sformatf("table row %0d", i));

    // R9 victim choice in set 6
    for (int k = 0; k < 4; k++)
      look(32'h0000_6000 | (k << 16), 0, 1, 0, 32'(k) << 20, 5'b00101, 1, 32'(k) << 20, 0, "R9");
    look(32'h0004_6000, 0, 1, 0, 32'h00F0_0000, 5'b00101, 1, 32'h00F0_0000, 0, "R9");
    v = nlook % NW;
    for (int k = 0; k < 4; k++)
      if (k != v) look(32'h0000_6000 | (k << 16), 0, 1, 0, 0, 0, 0, 32'(k) << 20, 0, "R9");
    look(32'h0000_6000 | (v << 16), 0, 1, 0, 32'(v) << 20, 5'b00101, 1, 32'(v) << 20, 0, "R9");

    // R8 rewalk keeps its way in a full set 7
    look(32'h0000_7000, 0, 1, 0, 32'h0100_0000, 5'b00001, 1, 32'h0100_0000, 0, "R8");
    for (int k = 1; k < 4; k++)
      look(32'h0000_7000 | (k << 16), 0, 1, 0, 32'h0100_0000 | (k << 20), 5'b00101, 1,
           32'h0100_0000 | (k << 20), 0, "R8");
    if ((nlook + 1) % NW == 0)
      look(32'h0001_7000, 0, 1, 0, 0, 0, 0, 32'h0110_0000, 0, "R8");
    look(32'h0000_7010, 0, 1, 1, 32'h0100_0000, 5'b00101, 1, 32'h0100_0010, 0, "R8");
    for (int k = 0; k < 4; k++)
      look(32'h0000_7000 | (k << 16), 0, 1, 0, 0, 0, 0, 32'h0100_0000 | (k << 20), 0, "R8");

    // R11 single-page flush
    look(32'h0000_8000, 0, 1, 0, 32'h0200_0000, 5'b10101, 1, 32'h0200_0000, 0, "R11");
    look(32'h0001_8000, 0, 1, 0, 32'h0210_0000, 5'b00101, 1, 32'h0210_0000, 0, "R11");
    look(32'h0001_8000, 0, 0, 0, 32'h0220_0000, 5'b00101, 1, 32'h0220_0000, 0, "R11");
    flush(0, 0, 32'h0001_8000, 0);
    look(32'h0001_8000, 0, 1, 0, 32'h0210_0000, 5'b00101, 1, 32'h0210_0000, 0, "R11 data");
    look(32'h0001_8000, 0, 0, 0, 32'h0220_0000, 5'b00101, 1, 32'h0220_0000, 0, "R11 instr");
    flush(0, 0, 32'h0000_8000, 0);
    look(32'h0000_8000, 0, 1, 0, 0, 0, 0, 32'h0200_0000, 0, "R11 global kept");
    flush(0, 1, 32'h0000_8000, 0);
    look(32'h0000_8000, 0, 1, 0, 32'h0200_0000, 5'b10101, 1, 32'h0200_0000, 0, "R11 global gone");

    // R12 flush-all
    look(32'h0000_9000, 0, 1, 0, 32'h0300_0000, 5'b10101, 1, 32'h0300_0000, 0, "R12");
    look(32'h0001_9000, 0, 1, 0, 32'h0310_0000, 5'b00101, 1, 32'h0310_0000, 0, "R12");
    flush(1, 0, 32'h0, 0);
    look(32'h0000_9000, 0, 1, 0, 0, 0, 0, 32'h0300_0000, 0, "R12 global kept");
    look(32'h0001_9000, 0, 1, 0, 32'h0310_0000, 5'b00101, 1, 32'h0310_0000, 0, "R12 plain gone");
    flush(1, 1, 32'h0, 0);
    look(32'h0000_9000, 0, 1, 0, 32'h0300_0000, 5'b10101, 1, 32'h0300_0000, 0, "R12 global gone");

    // R13 control write clears global entries too, then R4 8 KiB pages
    tcw(2'b10);
    look(32'h0000_9000, 0, 1, 0, 32'h0300_0000, 5'b10101, 1, 32'h0300_0000, 0, "R13");
    tcw(2'b11);
    look(32'h0001_3ABC, 0, 1, 0, 32'h00A0_1000, 5'b00101, 1, 32'h00A0_1ABC, 0, "R4");
    look(32'h0001_2000, 0, 1, 0, 0, 0, 0, 32'h00A0_0000, 0, "R4 same 8K page");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule